// File: doc/BRIEF.md
# Streaming 3x3 Image Convolution Engine

The engine filters a raster-ordered stream of 8-bit grayscale pixels from a 128x128 frame with a programmable 3x3 kernel. Pixels enter through a valid/ready port and a short FIFO. Two row stores keep the previous two rows. A sliding 3x3 window is built from those rows and the current pixel. Nine signed products are summed, and a separate register stage saturates the sum to 8 bits. Results leave through a valid/ready port in raster order, one for every interior pixel of the frame.

A one-hot controller with four states steps the row stores through the frame: idle, filling the first row, filling the second row, then sliding over the rest. The kernel can only be written while the engine is idle and fully drained. The asynchronous reset input is synchronised internally before it releases any register.

Back-pressure rules: the input is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` falls when the FIFO is full. While `out_valid_o` is high and `out_ready_i` is low, the whole pipeline holds still and the output value does not change. No window is lost or repeated.

Top module: `conv3x3_stream`

## Requirements
- R1: For each 128x128 frame of 8-bit unsigned pixels in raster order, the engine emits exactly 126x126 = 15876 results. They come in raster order of window centres (row y, column x) with 1 <= y <= 126 and 1 <= x <= 126. Border centres produce nothing.
- R2: The result for centre (y,x) is the sum over i,j in 0..2 of k[3*i+j] * p(y-1+i, x-1+j). Here k[n] is the signed 8-bit coefficient written with `coef_sel_i` = n, i = 0 is the oldest row and j = 0 is the leftmost column. The sum is held at a width at which no intermediate value can overflow.
- R3: No result is valid before the pixel at row 2, column 2 has been taken. The first result of a frame is the one centred at (1,1).
- R4: The row-store controller has four one-hot states: idle, fill row 0, fill row 1 and slide. It leaves idle on the first pixel, advances at the end of rows 0 and 1, and returns to idle after the last pixel of the frame. Each frame starts afresh.
- R5: A sum below 0 is output as 0, a sum above 255 as 255, and any other sum unchanged.
- R6: Saturation is a register stage one cycle after the product-sum register. With no stall, a result appears three clock edges after the edge that accepts the pixel completing its window.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_pixel_o` stays unchanged. `in_ready_o` is low whenever the FIFO is full. No pixel or result is lost or duplicated under any stall pattern.
- R8: While `arst_ni` is low, and for two rising clock edges after it rises, `in_ready_o` and `out_valid_o` are low.
- R9: A coefficient write (`coef_we_i` high, index 0..8) takes effect only when the controller is idle and the FIFO and pipeline are empty. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Engine can accept a pixel |
| in_pixel_i | input | 8 | Input pixel, unsigned |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 4 | Coefficient index, 3*row + column |
| coef_val_i | input | 8 | Coefficient value, signed |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts a result |
| out_pixel_o | output | 8 | Saturated result |

## Verification
The assertions check every cycle that:
- the controller state stays one-hot;
- no window is flagged valid while filling or in the two leftmost columns;
- the frame end returns the controller to idle;
- each stage hands its valid flag forward on advance;
- negative and large sums saturate in the following cycle;
- a stalled output holds its value;
- the FIFO is never pushed when full or popped when empty;
- the synchroniser keeps the inside in reset for the edge after release.

Only the bench's scenarios can show:
- that each result equals the kernel sum of the right pixels;
- that exactly 15876 results appear per frame;
- the three-edge latency;
- that a write made mid-frame leaves the kernel unchanged.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int K     = 3;
  localparam int TAPS  = K * K;
  localparam int SEL_W = $clog2(TAPS);

  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0001,
    ST_FILL0 = 4'b0010,
    ST_FILL1 = 4'b0100,
    ST_SLIDE = 4'b1000
  } lb_state_e;
endpackage

// File: rtl/conv_rst_sync.sv
module conv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

  // R8: the edge that first samples the released reset still keeps the inside in reset
  p_sync_delay_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(chain_q[0]) |-> !rst_no);
endmodule

// File: rtl/conv_fifo.sv
module conv_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rd_q];

  p_push_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_pop_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);
endmodule

// File: rtl/conv_window.sv
module conv_window import conv3_pkg::*; #(
  parameter int IMG_W = 128,
  parameter int IMG_H = 128,
  parameter int PIX_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  input  logic                  pix_valid_i,
  input  logic [PIX_W-1:0]      pix_i,
  output logic                  take_o,
  output logic                  win_valid_o,
  output logic [TAPS*PIX_W-1:0] win_o,
  output logic                  idle_o
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);

  lb_state_e      st_q, st_d;
  logic [CW-1:0]  col_q;
  logic [RW-1:0]  row_q;
  logic           wvalid_q;
  logic [PIX_W-1:0] up1_q [IMG_W];
  logic [PIX_W-1:0] up2_q [IMG_W];
  logic [PIX_W-1:0] win_q [K][K];
  logic [PIX_W-1:0] up1_rd, up2_rd;
  logic           take, col_last, row_last, centre_ok;

  assign take     = pix_valid_i && adv_i;
  assign take_o   = take;
  assign col_last = (col_q == CW'(IMG_W - 1));
  assign row_last = (row_q == RW'(IMG_H - 1));
  assign up1_rd   = up1_q[col_q];
  assign up2_rd   = up2_q[col_q];
  assign centre_ok = (st_q == ST_SLIDE) && (col_q >= CW'(K - 1));

  always_comb begin
    st_d = st_q;
    if (take) begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_FILL0;
        ST_FILL0: if (col_last) st_d = ST_FILL1;
        ST_FILL1: if (col_last) st_d = ST_SLIDE;
        ST_SLIDE: if (col_last && row_last) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      col_q    <= '0;
      row_q    <= '0;
      wvalid_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take) begin
        if (col_last) begin
          col_q <= '0;
          row_q <= row_last ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
      if (adv_i) wvalid_q <= take && centre_ok;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take) begin
      for (int i = 0; i < K; i++) begin
        for (int j = 0; j < K - 1; j++) win_q[i][j] <= win_q[i][j+1];
      end
      win_q[0][K-1] <= up2_rd;
      win_q[1][K-1] <= up1_rd;
      win_q[2][K-1] <= pix_i;
      up2_q[col_q]  <= up1_rd;
      up1_q[col_q]  <= pix_i;
    end
  end

  for (genvar i = 0; i < K; i++) begin : g_row
    for (genvar j = 0; j < K; j++) begin : g_col
      assign win_o[(K*i+j)*PIX_W +: PIX_W] = win_q[i][j];
    end
  end

  assign win_valid_o = wvalid_q;
  assign idle_o      = (st_q == ST_IDLE) && !wvalid_q;

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q) == 1);
  p_fill_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && st_q != ST_SLIDE) |=> !wvalid_q);
  p_border_cols_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && col_q < CW'(K - 1)) |=> !wvalid_q);
  p_frame_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && col_last && row_last) |=> st_q == ST_IDLE);
endmodule

// File: rtl/conv_arith.sv
module conv_arith import conv3_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic                     win_valid_i,
  input  logic [TAPS*PIX_W-1:0]    win_i,
  input  logic                     coef_we_i,
  input  logic [SEL_W-1:0]         coef_sel_i,
  input  logic signed [COEF_W-1:0] coef_val_i,
  output logic                     busy_o,
  output logic                     out_valid_o,
  output logic [PIX_W-1:0]         out_pix_o
);
  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);
  localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [COEF_W-1:0] k_q  [TAPS];
  logic signed [ACC_W-1:0]  prod [TAPS];
  logic signed [ACC_W-1:0]  sum, acc_q;
  logic                     mvalid_q, ovalid_q;
  logic [PIX_W-1:0]         sat, opix_q;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) k_q[t] <= '0;
      else if (coef_we_i && coef_sel_i == SEL_W'(t)) k_q[t] <= coef_val_i;
    end
    assign prod[t] = ACC_W'($signed({1'b0, win_i[t*PIX_W +: PIX_W]})) * ACC_W'(k_q[t]);
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++) sum = sum + prod[t];
  end

  always_comb begin
    if (acc_q < 0)         sat = '0;
    else if (acc_q > PMAX) sat = '1;
    else                   sat = acc_q[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mvalid_q <= 1'b0;
      acc_q    <= '0;
      ovalid_q <= 1'b0;
      opix_q   <= '0;
    end else if (adv_i) begin
      mvalid_q <= win_valid_i;
      acc_q    <= sum;
      ovalid_q <= mvalid_q;
      opix_q   <= sat;
    end
  end

  assign busy_o      = mvalid_q || ovalid_q;
  assign out_valid_o = ovalid_q;
  assign out_pix_o   = opix_q;

  p_mac_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && win_valid_i) |=> mvalid_q);
  p_sat_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mvalid_q) |=> ovalid_q);
  p_clamp_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mvalid_q && acc_q < 0) |=> out_pix_o == '0);
  p_clamp_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mvalid_q && acc_q > PMAX) |=> out_pix_o == '1);
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream import conv3_pkg::*; #(
  parameter int IMG_W      = 128,
  parameter int IMG_H      = 128,
  parameter int PIX_W      = 8,
  parameter int COEF_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     arst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [PIX_W-1:0]         in_pixel_i,
  input  logic                     coef_we_i,
  input  logic [SEL_W-1:0]         coef_sel_i,
  input  logic signed [COEF_W-1:0] coef_val_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [PIX_W-1:0]         out_pixel_o
);
  logic                  rst_n, adv, push, take;
  logic                  fifo_full, fifo_valid;
  logic [PIX_W-1:0]      fifo_data;
  logic                  win_valid, win_idle, arith_busy, idle, coef_ok;
  logic [TAPS*PIX_W-1:0] win;

  conv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .arst_ni(arst_ni), .rst_no(rst_n)
  );

  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = rst_n && !fifo_full;
  assign push       = in_valid_i && in_ready_o;

  conv_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_n),
    .push_i(push), .din_i(in_pixel_i), .full_o(fifo_full),
    .pop_i(take), .valid_o(fifo_valid), .dout_o(fifo_data)
  );

  conv_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_n), .adv_i(adv),
    .pix_valid_i(fifo_valid), .pix_i(fifo_data), .take_o(take),
    .win_valid_o(win_valid), .win_o(win), .idle_o(win_idle)
  );

  assign idle    = win_idle && !fifo_valid && !arith_busy;
  assign coef_ok = coef_we_i && idle;

  conv_arith #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_arith (
    .clk_i(clk_i), .rst_ni(rst_n), .adv_i(adv),
    .win_valid_i(win_valid), .win_i(win),
    .coef_we_i(coef_ok), .coef_sel_i(coef_sel_i), .coef_val_i(coef_val_i),
    .busy_o(arith_busy), .out_valid_o(out_valid_o), .out_pix_o(out_pixel_o)
  );

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pixel_o)));

  always_comb begin
    if (!rst_n) p_reset_gate_r8: assert (!in_ready_o && !out_valid_o);
  end
endmodule

// File: tb/conv3x3_stream_test.sv
`timescale 1ns/1ps
module conv3x3_stream_test;
  localparam int W = 128;
  localparam int H = 128;
  localparam int NOUT = (W - 2) * (H - 2);

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] in_pixel = '0;
  logic       coef_we = 1'b0;
  logic [3:0] coef_sel = '0;
  logic signed [7:0] coef_val = '0;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_pixel;

  always #2 clk = ~clk;

  conv3x3_stream uut (
    .clk_i(clk), .arst_ni(arst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pixel_i(in_pixel),
    .coef_we_i(coef_we), .coef_sel_i(coef_sel), .coef_val_i(coef_val),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pixel_o(out_pixel)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int kern [9];
  int unsigned fseed;
  bit fconst;
  int cval;
  string ftag = "R2";
  bit out_stall = 1'b0;
  int out_idx = 0;
  int first_out_cyc = -1;
  bit hold_pend = 1'b0;
  logic [7:0] hold_pix;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_of(int r, int c);
    int unsigned h;
    if (fconst) return 8'(cval);
    h = fseed ^ (32'(r) * 32'd131 + 32'(c) * 32'd7919);
    h = h * 32'h9E3779B1;
    h = h ^ (h >> 15);
    return h[7:0];
  endfunction

  function automatic logic [7:0] expect_px(int y, int x);
    int s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += kern[3*i+j] * int'(pix_of(y - 1 + i, x - 1 + j));
    if (s < 0) return 8'd0;
    if (s > 255) return 8'd255;
    return 8'(s);
  endfunction

  // output monitor: drives out_ready and checks every accepted result
  always @(negedge clk) begin
    bit rdy;
    logic [7:0] e;
    if (hold_pend)
      check(out_valid === 1'b1 && out_pixel == hold_pix, "R7 stalled output held",
            int'(out_pixel), int'(hold_pix));
    hold_pend = 1'b0;
    rdy = out_stall ? ($urandom % 3 != 0) : 1'b1;
    if (arst_n === 1'b0) rdy = 1'b0;
    out_ready = rdy;
    if (out_valid === 1'b1) begin
      if (first_out_cyc < 0) first_out_cyc = cyc;
      if (rdy) begin
        if (out_idx >= NOUT) begin
          check(1'b0, "R1 extra result in frame", out_idx + 1, NOUT);
        end else begin
          e = expect_px(1 + out_idx / (W - 2), 1 + out_idx % (W - 2));
          check(out_pixel == e, ftag, int'(out_pixel), int'(e));
        end
        out_idx++;
      end else begin
        hold_pend = 1'b1;
        hold_pix  = out_pixel;
      end
    end
  end

  task automatic load_kernel();
    for (int t = 0; t < 9; t++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_sel = 4'(t); coef_val = 8'(kern[t]);
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic drive_frame(input bit stall, input bit mid_write, output int hs_cyc);
    int n = 0;
    hs_cyc = -1;
    while (n < W * H) begin
      @(negedge clk);
      coef_we = 1'b0;
      if (stall && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_pixel = pix_of(n / W, n % W);
      end
      if (mid_write && n == 1000) begin
        coef_we = 1'b1; coef_sel = 4'd4; coef_val = 8'(kern[4]) ^ 8'h55;
      end
      if (in_valid && in_ready) begin
        if (n == 2 * W + 2) hs_cyc = cyc + 1;
        n++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; coef_we = 1'b0;
  endtask

  task automatic finish_frame();
    while (out_idx < NOUT) @(negedge clk);
    repeat (12) @(negedge clk);
    check(out_idx == NOUT, "R1 results per frame", out_idx, NOUT);
    check(out_valid === 1'b0, "R1 no result after frame end", int'(out_valid), 0);
    out_idx = 0;
    first_out_cyc = -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual %0d expected %0d", out_idx, NOUT);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hs;
    void'($urandom(32'd1234));
    // R8 reset behaviour
    repeat (4) @(negedge clk);
    check(in_ready === 1'b0, "R8 ready low in reset", int'(in_ready), 0);
    check(out_valid === 1'b0, "R8 valid low in reset", int'(out_valid), 0);
    arst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b0, "R8 ready low one edge after release", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready === 1'b1, "R8 ready high two edges after release", int'(in_ready), 1);

    // frame 1: small random kernel, random pixels, no stalls
    foreach (kern[t]) kern[t] = int'($urandom % 9) - 4;
    fseed = $urandom; fconst = 1'b0; ftag = "R2 kernel sum"; out_stall = 1'b0;
    load_kernel();
    drive_frame(1'b0, 1'b0, hs);
    while (first_out_cyc < 0) @(negedge clk);
    check(first_out_cyc == hs + 3, "R6 latency from completing pixel", first_out_cyc - hs, 3);
    check(hs >= 0, "R3 first result needs pixel (2,2)", hs, 1);
    finish_frame();

    // frame 2: full-range kernel, stalls both sides, write attempt mid-frame
    foreach (kern[t]) kern[t] = int'($urandom % 256) - 128;
    fseed = $urandom; ftag = "R2 R4 R7 R9 stalled frame, mid-frame write ignored";
    load_kernel();
    out_stall = 1'b1;
    drive_frame(1'b1, 1'b1, hs);
    finish_frame();
    out_stall = 1'b0;

    // frame 3: saturation high
    foreach (kern[t]) kern[t] = 0;
    kern[0] = 127;
    fconst = 1'b1; cval = 200; ftag = "R5 clamp to 255";
    load_kernel();
    drive_frame(1'b0, 1'b0, hs);
    finish_frame();

    // frame 4: saturation low
    kern[0] = 0; kern[8] = -1;
    ftag = "R5 clamp to 0";
    load_kernel();
    drive_frame(1'b0, 1'b0, hs);
    finish_frame();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule